// File: doc/BRIEF.md
# Host Event Signalling Controller

This block holds a register of pending host events and three enable masks, one each for the system-management interrupt (SMI), the system-control interrupt (SCI) and the wake line. When the event register or any mask changes, it re-evaluates all three outputs. The SMI output sends an active-low pulse only when the first enabled SMI event appears. The SCI output sends an active-low pulse on every re-evaluation that finds an enabled SCI event. The wake output is an active-low level that follows the enabled wake events, but the power-button event never drives it.

The host reads events through a query strobe. Each query scans the pending events upward from bit 0 and clears every set bit it passes. It stops at the first set bit that at least one mask enables and returns that bit's position plus one. If it reaches the top without such a bit, it returns 0. A resume input clears all three masks. All outputs stay high until firmware sets the init-done input.

Each pulse phase lasts `PHASE_CYC` clock cycles, so 3250 cycles at 50 MHz gives 65 µs. A request that arrives while a pulse is running is held. It produces one further pulse after the current one ends.

Top module: `host_event_ctrl`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_sel`: 0 the events, 1 the SMI mask, 2 the SCI mask, 3 the wake mask. `pending` shows the event register from the cycle after the write.
- R2: An SMI pulse starts only when a re-evaluation finds the masked SMI set non-zero while the internal SMI-armed flag is clear. The evaluation then sets the flag. An evaluation that finds the masked SMI set zero clears the flag.
- R3: Every mask write, resume, or event write whose value differs from the current events triggers one re-evaluation. An event write equal to the current value triggers none. Every re-evaluation with a non-zero masked SCI set requests an SCI pulse.
- R4: A pulse holds its line high for `PHASE_CYC` cycles and then low for exactly `PHASE_CYC` cycles. For a write sampled at clock edge E0, the line is first low after edge E0+`PHASE_CYC`+1.
- R5: Requests that arrive during a pulse merge into one extra pulse, which starts as soon as the current pulse ends.
- R6: `wake_n` is low exactly when the events ANDed with the wake mask are non-zero once bit `PWRBTN_BIT` is forced to zero. It changes one cycle after the registers change.
- R7: A query clears each set event bit from bit 0 upward, up to and including the first bit that some mask enables. `query_idx` then holds that bit's position plus 1, from the cycle after the strobe until the next query.
- R8: A query that finds no enabled pending event returns 0 and clears every pending event.
- R9: If a query and an event write fall in the same cycle, the query wins and the event write is ignored.
- R10: `resume` clears all three masks and takes priority over a mask write in the same cycle.
- R11: While `init_done` is low, all three outputs stay high and the pulse engines stay idle. The rising edge of `init_done` triggers a re-evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done | input | 1 | Enables the outputs |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 events, 1 SMI mask, 2 SCI mask, 3 wake mask) |
| wr_data | input | EVW | Write data |
| resume | input | 1 | Clears all masks |
| query | input | 1 | Query strobe |
| query_idx | output | $clog2(EVW+1) | Result of the last query, 1-based, 0 if none |
| pending | output | EVW | Current event register |
| smi_n | output | 1 | Active-low SMI pulse |
| sci_n | output | 1 | Active-low SCI pulse |
| wake_n | output | 1 | Active-low wake level |

## Verification
The bench builds the block with `EVW`=8, `PHASE_CYC`=4 and `PWRBTN_BIT`=2. With 8 events, every one of the 256 event patterns can be loaded and then queried until the register drains, and each result is compared against an arithmetic model. The short phase length lets the bench measure every pulse's low time and first-edge latency, and run back-to-back requests against a busy engine, within a few cycles per case.

// File: rtl/hev_pkg.sv
// Package: shared register select codes for the host event controller.
package hev_pkg;
    typedef enum logic [1:0] {
        SEL_EVENTS = 2'd0,
        SEL_SMI    = 2'd1,
        SEL_SCI    = 2'd2,
        SEL_WAKE   = 2'd3
    } hev_sel_e;
endpackage

// File: rtl/hev_regs.sv
// Module: hev_regs
// Holds the event register and the three masks, runs the query scan and
// flags every state change that requires the outputs to be re-evaluated.
// Assumes: one write and/or one query per cycle; query beats event write.
module hev_regs
    import hev_pkg::*;
#(
    parameter int EVW  = 32,
    localparam int IDXW = $clog2(EVW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [EVW-1:0]  wr_data,
    input  logic            resume,
    input  logic            query,
    output logic [EVW-1:0]  events,
    output logic [EVW-1:0]  m_smi,
    output logic [EVW-1:0]  m_sci,
    output logic [EVW-1:0]  m_wake,
    output logic [IDXW-1:0] q_idx,
    output logic            upd
);
    hev_sel_e       sel;
    logic [EVW-1:0] any_mask;
    logic [EVW-1:0] clr_bits;
    logic [IDXW-1:0] hit_idx;
    logic           found;
    logic           ev_wr;
    logic           mask_wr;

    assign sel      = hev_sel_e'(wr_sel);
    assign any_mask = m_smi | m_sci | m_wake;
    assign ev_wr    = wr_en && (sel == SEL_EVENTS) && !query && (wr_data != events);
    assign mask_wr  = resume || (wr_en && (sel != SEL_EVENTS));

    // Query scan: clear set bits upward until the first enabled one.
    always_comb begin
        found    = 1'b0;
        clr_bits = '0;
        hit_idx  = '0;
        for (int i = 0; i < EVW; i++) begin
            if (!found && events[i]) begin
                clr_bits[i] = 1'b1;
                if (any_mask[i]) begin
                    found   = 1'b1;
                    hit_idx = IDXW'(i + 1);
                end
            end
        end
    end

    // Event register and query result update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            events <= '0;
            q_idx  <= '0;
        end else if (query) begin
            events <= events & ~clr_bits;
            q_idx  <= hit_idx;
        end else if (ev_wr) begin
            events <= wr_data;
        end
    end

    // Mask registers; resume overrides any mask write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_smi  <= '0;
            m_sci  <= '0;
            m_wake <= '0;
        end else if (resume) begin
            m_smi  <= '0;
            m_sci  <= '0;
            m_wake <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_SMI:  m_smi  <= wr_data;
                SEL_SCI:  m_sci  <= wr_data;
                SEL_WAKE: m_wake <= wr_data;
                default:  ;
            endcase
        end
    end

    // Re-evaluation flag, valid in the cycle after a change.
    always_ff @(posedge clk) begin
        if (!rst_n) upd <= 1'b0;
        else        upd <= ev_wr || mask_wr || (query && (clr_bits != '0));
    end

    // R9: a query cycle never sets an event bit.
    a_r9_query_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        query |=> ((events & ~$past(events)) == '0));
    // R10: resume leaves all masks at zero.
    a_r10_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> (m_smi == '0 && m_sci == '0 && m_wake == '0));
endmodule

// File: rtl/hev_pulser.sv
// Module: hev_pulser
// Produces one active-low pulse (high phase then low phase, PHASE cycles
// each) per request; requests during a pulse merge into one more pulse.
// Assumes: en low forces the engine idle and drops held requests.
module hev_pulser #(
    parameter int PHASE = 3250,
    localparam int CW = (PHASE > 1) ? $clog2(PHASE) : 1,
    localparam int RW = $clog2(PHASE + 1) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    output logic line_n
);
    typedef enum logic [1:0] {P_IDLE, P_HIGH, P_LOW} pstate_e;

    pstate_e        state;
    logic [CW-1:0]  cnt;
    logic           pend;
    logic           last;

    assign last   = (cnt == CW'(PHASE - 1));
    assign line_n = (state != P_LOW);

    // Phase sequencer with one held request.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state <= P_IDLE;
            cnt   <= '0;
            pend  <= 1'b0;
        end else begin
            case (state)
                P_IDLE: begin
                    cnt <= '0;
                    if (req) state <= P_HIGH;
                end
                P_HIGH: begin
                    pend <= pend | req;
                    if (last) begin
                        state <= P_LOW;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (last) begin
                        cnt   <= '0;
                        pend  <= 1'b0;
                        state <= (pend || req) ? P_HIGH : P_IDLE;
                    end else begin
                        cnt  <= cnt + 1'b1;
                        pend <= pend | req;
                    end
                end
            endcase
        end
    end

    // Checker counters: consecutive low and (saturating) high cycles.
    logic [RW-1:0] lo_run;
    logic [RW-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run <= '0;
            hi_run <= '0;
        end else begin
            lo_run <= line_n ? '0 : lo_run + 1'b1;
            hi_run <= !line_n ? '0 : ((hi_run < RW'(PHASE)) ? hi_run + 1'b1 : hi_run);
        end
    end

    // R4: the low phase never exceeds PHASE cycles.
    a_r4_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !line_n |-> (lo_run <= RW'(PHASE - 1)));
    // R4: every falling edge follows at least PHASE high cycles.
    a_r4_high_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_n) |-> (hi_run >= RW'(PHASE)));
    // R11: a disabled engine leaves its line high.
    a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> line_n);
endmodule

// File: rtl/host_event_ctrl.sv
// Module: host_event_ctrl (top)
// Evaluates the masked event sets on every change and drives the SMI/SCI
// pulse engines and the wake level.
// Assumes: init_done gates all outputs; PWRBTN_BIT < EVW.
module host_event_ctrl #(
    parameter int EVW        = 32,
    parameter int PHASE_CYC  = 3250,
    parameter int PWRBTN_BIT = 0,
    localparam int IDXW = $clog2(EVW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_done,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [EVW-1:0]  wr_data,
    input  logic            resume,
    input  logic            query,
    output logic [IDXW-1:0] query_idx,
    output logic [EVW-1:0]  pending,
    output logic            smi_n,
    output logic            sci_n,
    output logic            wake_n
);
    localparam logic [EVW-1:0] PB_MASK = {{(EVW-1){1'b0}}, 1'b1} << PWRBTN_BIT;

    logic [EVW-1:0] events, m_smi, m_sci, m_wake;
    logic upd, init_q, eval, smi_flag;
    logic smi_hit, sci_hit, wake_hit, smi_req, sci_req;

    hev_regs #(.EVW(EVW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .resume(resume), .query(query),
        .events(events), .m_smi(m_smi), .m_sci(m_sci), .m_wake(m_wake),
        .q_idx(query_idx), .upd(upd)
    );

    assign pending  = events;
    assign eval     = init_done && (upd || !init_q);
    assign smi_hit  = |(events & m_smi);
    assign sci_hit  = |(events & m_sci);
    assign wake_hit = |(events & m_wake & ~PB_MASK);
    assign smi_req  = eval && smi_hit && !smi_flag;
    assign sci_req  = eval && sci_hit;

    // Init edge tracking and SMI-armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q   <= 1'b0;
            smi_flag <= 1'b0;
        end else begin
            init_q <= init_done;
            if (eval) smi_flag <= smi_hit;
        end
    end

    // Wake level, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_n <= 1'b1;
        else        wake_n <= !(init_done && wake_hit);
    end

    hev_pulser #(.PHASE(PHASE_CYC)) u_smi (
        .clk(clk), .rst_n(rst_n), .en(init_done), .req(smi_req), .line_n(smi_n)
    );
    hev_pulser #(.PHASE(PHASE_CYC)) u_sci (
        .clk(clk), .rst_n(rst_n), .en(init_done), .req(sci_req), .line_n(sci_n)
    );

    // R6: an enabled non-power-button wake event pulls wake low next cycle.
    a_r6_wake_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && |(events & m_wake & ~PB_MASK)) |=> !wake_n);
    // R11: wake stays high while not initialised.
    a_r11_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |=> wake_n);
endmodule

// File: tb/host_event_ctrl_bench.sv
module host_event_ctrl_bench;
    localparam int EVW = 8, P = 4, PB = 2, IDXW = 4;

    logic clk = 0, rst_n = 0, init_done = 0, wr_en = 0, resume = 0, query = 0;
    logic [1:0] wr_sel = 0;
    logic [EVW-1:0] wr_data = 0;
    logic [IDXW-1:0] query_idx;
    logic [EVW-1:0] pending;
    logic smi_n, sci_n, wake_n;
    int checks = 0, errors = 0;
    int smi_falls = 0, sci_falls = 0, bad_width = 0;
    int smi_run = 0, sci_run = 0;
    logic smi_p = 1, sci_p = 1;
    bit done = 0;

    always #10 clk = ~clk;

    host_event_ctrl #(.EVW(EVW), .PHASE_CYC(P), .PWRBTN_BIT(PB)) u_host_event_ctrl (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .resume(resume), .query(query),
        .query_idx(query_idx), .pending(pending),
        .smi_n(smi_n), .sci_n(sci_n), .wake_n(wake_n)
    );

    // Pulse monitor: falling edges and low-phase widths (R4).
    always @(negedge clk) if (rst_n) begin
        if (smi_p && !smi_n) smi_falls++;
        if (sci_p && !sci_n) sci_falls++;
        if (!smi_n) smi_run++; else begin if (smi_run != 0 && smi_run != P) bad_width++; smi_run = 0; end
        if (!sci_n) sci_run++; else begin if (sci_run != 0 && sci_run != P) bad_width++; sci_run = 0; end
        smi_p = smi_n; sci_p = sci_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [EVW-1:0] d);
        @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic do_query();
        @(negedge clk); query = 1;
        @(negedge clk); query = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Independent model of the query scan (R7, R8).
    function automatic void model_q(input logic [EVW-1:0] ev, input logic [EVW-1:0] am,
                                    output int idx, output logic [EVW-1:0] nev);
        idx = 0; nev = ev;
        for (int i = 0; i < EVW; i++) begin
            if (nev[i]) begin
                nev[i] = 1'b0;
                if (am[i]) begin idx = i + 1; break; end
            end
        end
    endfunction

    initial begin
        int s0, c0, eidx;
        logic [EVW-1:0] enev, cur;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        chk(smi_n && sci_n && wake_n, "R11 reset outputs", {smi_n, sci_n, wake_n}, 7);
        chk(pending == 0, "R1 reset pending", pending, 0);
        chk(query_idx == 0, "R7 reset idx", query_idx, 0);

        // R11: no activity before init, evaluation on init rise
        wr(1, 8'h01); wr(3, 8'h01); wr(0, 8'h01);
        idle(3 * P);
        chk(smi_falls == 0 && wake_n, "R11 gated before init", smi_falls, 0);
        chk(pending == 8'h01, "R1 event write", pending, 8'h01);
        @(negedge clk); init_done = 1;
        idle(3 * P);
        chk(smi_falls == 1, "R11 init rise evaluates", smi_falls, 1);
        chk(!wake_n, "R6 wake low", wake_n, 0);
        wr(0, 8'h00); idle(2);
        chk(wake_n, "R6 wake released", wake_n, 1);

        // R4: latency and shape of an SMI pulse
        wr(0, 8'h01);
        repeat (P) @(negedge clk);
        chk(smi_n, "R4 high at E0+P", smi_n, 1);
        @(negedge clk);
        chk(!smi_n, "R4 low at E0+P+1", smi_n, 0);
        idle(2 * P);
        chk(smi_falls == 2, "R2 first SMI", smi_falls, 2);

        // R2: armed flag blocks a repeat, clears when masked set empties
        wr(0, 8'h03); idle(3 * P);
        chk(smi_falls == 2, "R2 no repeat SMI", smi_falls, 2);
        wr(0, 8'h02); wr(0, 8'h01); idle(3 * P);
        chk(smi_falls == 3, "R2 re-armed SMI", smi_falls, 3);

        // R3: SCI on every evaluation, none on an equal event write
        wr(2, 8'h10); idle(3 * P);
        c0 = sci_falls;
        wr(0, 8'h11); idle(3 * P);
        chk(sci_falls == c0 + 1, "R3 SCI pulse", sci_falls, c0 + 1);
        wr(0, 8'h11); idle(3 * P);
        chk(sci_falls == c0 + 1, "R3 equal write silent", sci_falls, c0 + 1);
        wr(0, 8'h31); idle(3 * P);
        chk(sci_falls == c0 + 2, "R3 second SCI", sci_falls, c0 + 2);
        chk(smi_falls == 3, "R2 SMI stays armed", smi_falls, 3);

        // R5: three requests during a pulse give two pulses
        c0 = sci_falls;
        wr(0, 8'h10); wr(0, 8'h30); wr(0, 8'h10);
        idle(8 * P);
        chk(sci_falls == c0 + 2, "R5 merged requests", sci_falls, c0 + 2);

        // R6: power-button bit excluded from wake
        wr(3, 8'h04); wr(0, 8'h04); idle(3 * P);
        chk(wake_n, "R6 power button ignored", wake_n, 1);
        wr(3, 8'h0C); wr(0, 8'h08); idle(2);
        chk(!wake_n, "R6 wake asserted", wake_n, 0);

        // R10: resume clears masks and beats a same-cycle mask write
        idle(3 * P);
        @(negedge clk); resume = 1;
        @(negedge clk); resume = 0; wr_en = 1; wr_sel = 2; wr_data = 8'hFF; resume = 1;
        @(negedge clk); wr_en = 0; resume = 0;
        idle(2);
        chk(wake_n, "R10 wake mask cleared", wake_n, 1);
        idle(3 * P);
        c0 = sci_falls;
        wr(0, 8'h80); idle(3 * P);
        chk(sci_falls == c0, "R10 SCI mask cleared", sci_falls, c0);
        do_query();
        chk(query_idx == 0, "R8 no enabled event idx", query_idx, 0);
        chk(pending == 0, "R8 all cleared", pending, 0);

        // R9: query beats event write
        wr(1, 8'h02); wr(0, 8'h06); idle(3 * P);
        @(negedge clk); query = 1; wr_en = 1; wr_sel = 0; wr_data = 8'hF0;
        @(negedge clk); query = 0; wr_en = 0;
        chk(query_idx == 2, "R9 query index", query_idx, 2);
        chk(pending == 8'h04, "R9 write ignored", pending, 8'h04);
        idle(3 * P);

        // R7/R8: exhaustive query sweep, outputs held off (R11)
        @(negedge clk); init_done = 0;
        wr(1, 8'h11); wr(2, 8'h40); wr(3, 8'h06);
        for (int v = 0; v < 256; v++) begin
            wr(0, v[EVW-1:0]);
            cur = v[EVW-1:0];
            for (int k = 0; k < 9; k++) begin
                model_q(cur, 8'h57, eidx, enev);
                do_query();
                chk(query_idx == eidx, "R7 query index", query_idx, eidx);
                chk(pending == enev, "R7 query clear", pending, enev);
                cur = enev;
                if (eidx == 0) break;
            end
            chk(smi_n && sci_n && wake_n, "R11 quiet while off", {smi_n, sci_n, wake_n}, 7);
        end
        chk(bad_width == 0, "R4 low width", bad_width, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule